// File: doc/BRIEF.md
# Temperature Conversion Mode Sequencer

This block decides when a temperature converter is told to start a measurement. A two-bit operating-mode field, presented together with a write strobe, selects one of three behaviours. In continuous operation conversions run back to back. In one-shot operation each write launches a single conversion, after which the block waits. In shutdown nothing is launched and the most recent result stays available.

Conversion length and the wake-up delay after shutdown are counted in pulses of an external timebase tick. The defaults are 240 ticks per conversion and 1 tick of wake-up, which suits a millisecond timebase. At the end of every conversion the block captures the converter's data into a result register and raises a one-clock valid strobe for the downstream alarm logic. A mode write that arrives while a conversion or a wake-up is in progress is held and acts at the end of that activity. A later held write replaces an earlier one.

Top module: `conv_mode_seq`

## Requirements
- R1: While `rst_n` is low, `conv_start`, `busy` and `result_vld` are 0, `result` is 0, and the stored mode is continuous.
- R2: In continuous mode the field is 00 or 01 (bit 1 clear). Each completed conversion immediately launches the next one: `conv_start` is high in the same cycle as `result_vld`. After reset the first conversion starts in the first cycle after `rst_n` rises.
- R3: A write of field 10 while the block is idle starts exactly one conversion. `conv_start` is high in the cycle after the write. After that conversion completes, `busy` and `conv_start` stay low until the next write.
- R4: A write of field 11 selects shutdown. While shut down, `conv_start` never rises and `busy` is low.
- R5: While shut down, `result` keeps the value captured by the last conversion completed before shutdown, whatever `conv_data` does.
- R6: A write of any field other than 11 during shutdown makes `busy` rise at once without a start. After WAKE_TICKS timebase ticks, `conv_start` pulses and a conversion begins.
- R7: From the cycle in which `conv_start` is high up to the cycle before `result_vld`, exactly CONV_TICKS ticks are consumed. `result` then equals the `conv_data` value present on the clock edge that ends the conversion.
- R8: A mode write while `busy` is high causes no start and no change of activity before the current conversion or wake-up ends. It takes effect at that end. A held one-shot write launches one further conversion.
- R9: `result_vld` is never high in two consecutive cycles.
- R10: `busy` is high exactly while a conversion or a wake-up is in progress, and `conv_start` only rises together with `busy`.
- R11: A mode write in the same cycle as the tick that completes a conversion governs that completion. With 11 the block goes to shutdown after delivering the result. With 10 it launches one one-shot conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | One-cycle strobe: mode_field is written |
| mode_field | input | 2 | Operating mode: 11 shutdown, 10 one-shot, 00/01 continuous |
| tick | input | 1 | Timebase pulse that advances the conversion and wake timers |
| conv_data | input | DATA_W | Converter output, sampled when a conversion ends |
| conv_start | output | 1 | One-cycle conversion start pulse to the converter |
| busy | output | 1 | Conversion or wake-up in progress |
| result_vld | output | 1 | One-cycle strobe: result holds a new value |
| result | output | DATA_W | Last captured conversion result |

## Verification
A mode write and the tick that finishes a conversion can land on the same clock edge. Then the write decides what follows the result, instead of being held for a later end. The bench provokes this by watching its own model's tick count and asserting `mode_wr` with 11, and later with 10, on exactly the cycle whose tick ends the conversion. It judges the outcome by requiring the valid strobe in that cycle. For 11 there must be no start afterwards; for 10 there must be a start in the same cycle followed by idling after the next result. The per-clock model comparison covers every other cycle of those sequences.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_WAKE  = 2'd2,
      ST_SLEEP = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      MD_CONT = 2'd0,
      MD_ONCE = 2'd1,
      MD_OFF  = 2'd2
   } seq_mode_e;

   // Field 11 -> shutdown, 10 -> one-shot, anything with bit 1 clear -> continuous
   function automatic seq_mode_e decode_field(input logic [1:0] f);
      seq_mode_e m;
      case (f)
         2'b11:   m = MD_OFF;
         2'b10:   m = MD_ONCE;
         default: m = MD_CONT;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/seq_mode_dec.sv
module seq_mode_dec
   import seq_pkg::*;
(
   input  logic [1:0] field,
   output seq_mode_e  mode
);
   always_comb mode = decode_field(field);
endmodule

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
   parameter int CONV_TICKS = 240,
   parameter int WAKE_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   input  logic sel_wake,
   input  logic tick,
   output logic done
);
   localparam int MAXT    = (CONV_TICKS > WAKE_TICKS) ? CONV_TICKS : WAKE_TICKS;
   localparam int CNT_W   = $clog2(MAXT + 1);
   localparam int WAKE_M1 = (WAKE_TICKS > 0) ? WAKE_TICKS - 1 : 0;
   localparam logic [CNT_W-1:0] CONV_LIM = CNT_W'(CONV_TICKS - 1);
   localparam logic [CNT_W-1:0] WAKE_LIM = CNT_W'(WAKE_M1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   always_comb lim  = sel_wake ? WAKE_LIM : CONV_LIM;
   always_comb done = run && tick && (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || clr || !run)
         cnt_q <= '0;
      else if (tick && !done)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/seq_result_reg.sv
module seq_result_reg #(
   parameter int DATA_W      = 13,
   parameter bit CLR_ON_RST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   generate
      if (CLR_ON_RST) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (cap) q <= d;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (cap) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq
   import seq_pkg::*;
#(
   parameter int DATA_W     = 13,
   parameter int CONV_TICKS = 240,
   parameter int WAKE_TICKS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [1:0]        mode_field,
   input  logic              tick,
   input  logic [DATA_W-1:0] conv_data,
   output logic              conv_start,
   output logic              busy,
   output logic              result_vld,
   output logic [DATA_W-1:0] result
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("conv_mode_seq: DATA_W must be at least 1");
      end
      if (CONV_TICKS < 1) begin : g_bad_conv
         $error("conv_mode_seq: CONV_TICKS must be at least 1");
      end
      if (WAKE_TICKS < 0) begin : g_bad_wake
         $error("conv_mode_seq: WAKE_TICKS must not be negative");
      end
   endgenerate

   seq_state_e state_q, state_d;
   seq_mode_e  mode_q, mode_d, wr_mode, pmode_q, pmode_d, eff_mode;
   logic       pend_q, pend_d, eff_fresh;
   logic       launch, wake_entry, done, finish_conv;
   logic       start_q, vld_q, wake_en;

   generate
      if (WAKE_TICKS > 0) begin : g_wake_on
         assign wake_en = 1'b1;
      end else begin : g_wake_off
         assign wake_en = 1'b0;
      end
   endgenerate

   seq_mode_dec dec_i (
      .field (mode_field),
      .mode  (wr_mode)
   );

   seq_tick_timer #(
      .CONV_TICKS (CONV_TICKS),
      .WAKE_TICKS (WAKE_TICKS)
   ) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .clr      (launch | wake_entry),
      .sel_wake (state_q == ST_WAKE),
      .tick     (tick),
      .done     (done)
   );

   // A write in this cycle outranks one held from earlier
   always_comb begin
      eff_fresh = mode_wr | pend_q;
      if (mode_wr)     eff_mode = wr_mode;
      else if (pend_q) eff_mode = pmode_q;
      else             eff_mode = mode_q;
   end

   always_comb finish_conv = (state_q == ST_CONV) && done;

   always_comb begin
      state_d    = state_q;
      mode_d     = mode_q;
      pend_d     = pend_q;
      pmode_d    = pmode_q;
      launch     = 1'b0;
      wake_entry = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (mode_wr) begin
               mode_d = wr_mode;
               if (wr_mode == MD_OFF) state_d = ST_SLEEP;
               else                   launch  = 1'b1;
            end else if (mode_q == MD_CONT) begin
               launch = 1'b1;
            end
         end
         ST_CONV: begin
            if (done) begin
               pend_d = 1'b0;
               mode_d = eff_mode;
               if (eff_mode == MD_OFF)                      state_d = ST_SLEEP;
               else if (eff_mode == MD_ONCE && !eff_fresh) state_d = ST_IDLE;
               else                                         launch  = 1'b1;
            end else if (mode_wr) begin
               pend_d  = 1'b1;
               pmode_d = wr_mode;
            end
         end
         ST_WAKE: begin
            if (done) begin
               pend_d = 1'b0;
               mode_d = eff_mode;
               if (eff_mode == MD_OFF) state_d = ST_SLEEP;
               else                    launch  = 1'b1;
            end else if (mode_wr) begin
               pend_d  = 1'b1;
               pmode_d = wr_mode;
            end
         end
         ST_SLEEP: begin
            if (mode_wr && wr_mode != MD_OFF) begin
               mode_d = wr_mode;
               if (wake_en) begin
                  state_d    = ST_WAKE;
                  wake_entry = 1'b1;
               end else begin
                  launch = 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (launch) state_d = ST_CONV;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MD_CONT;
         pend_q  <= 1'b0;
         pmode_q <= MD_CONT;
         start_q <= 1'b0;
         vld_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         mode_q  <= mode_d;
         pend_q  <= pend_d;
         pmode_q <= pmode_d;
         start_q <= launch;
         vld_q   <= finish_conv;
      end
   end

   seq_result_reg #(
      .DATA_W     (DATA_W),
      .CLR_ON_RST (1'b1)
   ) res_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (finish_conv),
      .d     (conv_data),
      .q     (result)
   );

   assign busy       = (state_q == ST_CONV) || (state_q == ST_WAKE);
   assign conv_start = start_q;
   assign result_vld = vld_q;

endmodule

// File: rtl/conv_mode_seq_chk.sv
module conv_mode_seq_chk
   import seq_pkg::*;
#(
   parameter int DATA_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input seq_state_e        state,
   input logic              conv_start,
   input logic              busy,
   input logic              result_vld,
   input logic [DATA_W-1:0] result
);
   p_vld_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld |=> !result_vld);

   p_sleep_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLEEP) |-> (!conv_start && !busy));

   p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLEEP && $past(state) == ST_SLEEP) |-> $stable(result));

   p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   p_chain_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && $past(busy)) |-> (result_vld || $past(state) == ST_WAKE));

   p_vld_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld |-> $past(busy));
endmodule

bind conv_mode_seq conv_mode_seq_chk #(.DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .state      (state_q),
   .conv_start (conv_start),
   .busy       (busy),
   .result_vld (result_vld),
   .result     (result)
);

// File: tb/conv_mode_seq_tb_top.sv
module conv_mode_seq_tb_top;
   localparam int DW   = 12;
   localparam int CT   = 4;
   localparam int WT   = 2;
   localparam int TDIV = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wr = 1'b0;
   logic [1:0]    mode_field = 2'b00;
   logic          tick;
   logic [DW-1:0] conv_data;
   logic          conv_start, busy, result_vld;
   logic [DW-1:0] result;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done_flag = 0;

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;
   assign tick      = rst_n && (cyc % TDIV == TDIV - 1);
   assign conv_data = DW'(cyc * 37 + 5);

   conv_mode_seq #(.DATA_W(DW), .CONV_TICKS(CT), .WAKE_TICKS(WT)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_field(mode_field),
      .tick(tick), .conv_data(conv_data), .conv_start(conv_start),
      .busy(busy), .result_vld(result_vld), .result(result));

   // Behavioural reference: states 0 idle, 1 converting, 2 waking, 3 asleep
   // Modes: 0 continuous, 2 one-shot, 3 shutdown
   int m_state, m_cnt, m_mode, m_pmode;
   bit m_pend, m_start, m_vld;
   int m_res;

   always @(posedge clk) begin
      int  wm, em;
      bit  dn, fr, go;
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_mode = 0; m_pmode = 0;
         m_pend = 0; m_start = 0; m_vld = 0; m_res = 0;
      end else begin
         wm = (mode_field[1] == 1'b0) ? 0 : int'(mode_field);
         dn = tick && ((m_state == 1 && m_cnt == CT - 1) || (m_state == 2 && m_cnt == WT - 1));
         m_start = 0; m_vld = 0; go = 0;
         if ((m_state == 1 || m_state == 2) && tick && !dn) m_cnt++;
         fr = mode_wr || m_pend;
         em = mode_wr ? wm : (m_pend ? m_pmode : m_mode);
         case (m_state)
            0: begin
               if (mode_wr) begin
                  m_mode = wm;
                  if (wm == 3) m_state = 3; else go = 1;
               end else if (m_mode == 0) go = 1;
            end
            1: begin
               if (dn) begin
                  m_res = int'(conv_data); m_vld = 1; m_pend = 0; m_mode = em;
                  if (em == 3) m_state = 3;
                  else if (em == 2 && !fr) m_state = 0;
                  else go = 1;
               end else if (mode_wr) begin m_pend = 1; m_pmode = wm; end
            end
            2: begin
               if (dn) begin
                  m_pend = 0; m_mode = em;
                  if (em == 3) m_state = 3; else go = 1;
               end else if (mode_wr) begin m_pend = 1; m_pmode = wm; end
            end
            default: begin
               if (mode_wr && wm != 3) begin
                  m_mode = wm; m_state = 2; m_cnt = 0;
               end
            end
         endcase
         if (go) begin m_state = 1; m_cnt = 0; m_start = 1; end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // R10 and all others: per-clock comparison with the model
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk(conv_start == m_start, "R10 model start", int'(conv_start), int'(m_start));
         chk(busy == (m_state == 1 || m_state == 2), "R10 model busy", int'(busy),
             int'(m_state == 1 || m_state == 2));
         chk(result_vld == m_vld, "R9 model valid", int'(result_vld), int'(m_vld));
         chk(int'(result) == m_res, "R7 model result", int'(result), m_res);
      end
   end

   task automatic wr(input logic [1:0] f);
      @(negedge clk);
      mode_wr = 1'b1; mode_field = f;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic wait_start();
      for (int i = 0; i < 200 && !conv_start; i++) @(negedge clk);
   endtask

   task automatic wait_vld();
      for (int i = 0; i < 200 && !result_vld; i++) @(negedge clk);
   endtask

   // Wait for the negedge whose next edge carries the completing tick
   task automatic wait_last_tick();
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (m_state == 1 && m_cnt == CT - 1 && tick) break;
      end
   endtask

   initial begin
      int n, starts, held;
      bit bsy;
      repeat (3) @(negedge clk);
      chk(!conv_start && !busy && !result_vld && result == '0, "R1 reset outputs",
          int'({conv_start, busy, result_vld}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(conv_start == 1'b1, "R2 first start after reset", int'(conv_start), 1);

      // R7: tick count from start to valid
      n = 0;
      while (!result_vld && n < 100) begin
         if (tick) n++;
         @(negedge clk);
      end
      chk(n == CT, "R7 ticks per conversion", n, CT);
      chk(int'(result) == m_res, "R7 captured value", int'(result), m_res);
      chk(conv_start == 1'b1, "R2 back-to-back start", int'(conv_start), 1);
      @(negedge clk);
      chk(result_vld == 1'b0, "R9 strobe one clock", int'(result_vld), 0);

      // R8: one-shot write mid-conversion is held
      wr(2'b10);
      starts = 0;
      while (!result_vld) begin
         if (conv_start) starts++;
         @(negedge clk);
      end
      chk(starts == 0, "R8 no start before end", starts, 0);
      chk(conv_start == 1'b1, "R8 held one-shot launches", int'(conv_start), 1);
      @(negedge clk);
      wait_vld();
      chk(conv_start == 1'b0, "R3 no restart after one-shot", int'(conv_start), 0);
      starts = 0; bsy = 0;
      repeat (20) begin @(negedge clk); if (conv_start) starts++; if (busy) bsy = 1; end
      chk(starts == 0 && !bsy, "R3 idle after one-shot", starts, 0);

      // R3: one-shot from idle
      wr(2'b10);
      chk(conv_start == 1'b1, "R3 start next cycle", int'(conv_start), 1);
      starts = 0;
      repeat (30) begin @(negedge clk); if (conv_start) starts++; end
      chk(starts == 0 && !busy, "R3 single conversion", starts, 0);

      // R4/R5: continuous, then shutdown written mid-conversion
      wr(2'b01);
      chk(conv_start == 1'b1, "R2 continuous via 01", int'(conv_start), 1);
      @(negedge clk);
      wr(2'b11);
      wait_vld();
      held = int'(result);
      starts = 0; bsy = 0;
      repeat (40) begin @(negedge clk); if (conv_start) starts++; if (busy) bsy = 1; end
      chk(starts == 0 && !bsy, "R4 no activity in shutdown", starts, 0);
      chk(int'(result) == held, "R5 result held", int'(result), held);

      // R6: leave shutdown
      wr(2'b00);
      chk(busy == 1'b1 && conv_start == 1'b0, "R6 wake busy without start",
          int'({busy, conv_start}), 2);
      n = 0;
      while (!conv_start && n < 100) begin
         if (tick) n++;
         @(negedge clk);
      end
      chk(n == WT, "R6 wake ticks", n, WT);

      // R11: shutdown written on the completing cycle
      wait_last_tick();
      mode_wr = 1'b1; mode_field = 2'b11;
      @(negedge clk);
      mode_wr = 1'b0;
      chk(result_vld == 1'b1 && conv_start == 1'b0, "R11 shutdown at completion",
          int'({result_vld, conv_start}), 2);
      starts = 0;
      repeat (12) begin @(negedge clk); if (conv_start) starts++; end
      chk(starts == 0 && !busy, "R11 asleep after completion", starts, 0);

      // R11: one-shot written on the completing cycle
      wr(2'b00);
      wait_start();
      wait_last_tick();
      mode_wr = 1'b1; mode_field = 2'b10;
      @(negedge clk);
      mode_wr = 1'b0;
      chk(result_vld == 1'b1 && conv_start == 1'b1, "R11 one-shot at completion",
          int'({result_vld, conv_start}), 3);
      @(negedge clk);
      wait_vld();
      chk(conv_start == 1'b0, "R11 idle after one-shot", int'(conv_start), 0);
      repeat (5) @(negedge clk);
      chk(!busy, "R11 stays idle", int'(busy), 0);

      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #2000000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule